// File: doc/BRIEF.md
# Four-Channel PWM Generator with Shared Period Dividers

The block produces four pulse-width modulated outputs from one clock. Four 16-bit period dividers each turn the clock into a step tick every D cycles. Each output channel picks one of the four dividers through a two-bit select field. It advances an 8-bit step counter on that divider's ticks and drives its output high while the step count is below the channel's duty value. A full period is therefore 256 × D clock cycles, and the high phase is D × duty cycles. Every period begins high.

Software programs the block through a plain register port: a write strobe, a byte address and 32 bits of write data, with combinational read data. Writing a divider or a duty register applies the new setting at once. The affected step counters, and for a divider write also that divider's cycle counter, restart from zero, so the period in progress is abandoned. Per channel there is an output enable, a bypass that holds the output high, and a counting enable that gates the divider carrying the same index.

Register layout: mode register at 0x00 (bits 3:0 output enable per channel, bits 11:8 bypass per channel); count-enable register at 0x04 (bits 3:0); divider i at 0x10 + 4·i (bits 15:0); duty register of channel i at 0x20 + 4·i (bits 7:0 duty, bits 9:8 divider select).

Top module: `pwm_quad`

## Requirements
- R1: A synchronous active-high reset clears all registers, counters and outputs. After reset every register reads zero and all outputs are low.
- R2: Each register reads back its last written value with unused bits as zero: mode masks to 0x0F0F, count enable to 0x000F, divider to 0xFFFF, duty to 0x03FF. Any unmapped address reads zero.
- R3: With output enabled, bypass clear, count enable set and divider value D nonzero, the output starts high right after the restart. It stays high D × duty cycles, then low (256 − duty) × D cycles, so the period is 256 × D cycles.
- R4: The duty register select field (bits 9:8) chooses which of the four dividers paces the channel's step counter. Channels using dividers with different D values show periods scaled by that divider's D.
- R5: A duty value of 0 with bypass clear keeps the output low at all times.
- R6: An enabled channel with its bypass bit set drives a constant high, whatever its duty.
- R7: A channel whose output enable is clear drives low, even with its bypass bit set.
- R8: A divider whose count enable is clear, or whose value is 0, emits no ticks. The step counters fed by it stand still and their outputs hold their level.
- R9: A write to a duty register, or to the divider a channel selects, clears that channel's step counter at once. A divider write also clears the divider's cycle counter, so a mid-period change produces a full new period at the new settings.
- R10: A running divider with value D emits a one-cycle tick exactly every D cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | PWM outputs, one per channel |

## Verification
The assertions rely on the register port being driven only with word-aligned addresses and on reset being held for at least one clock before operation. The tick-spacing check also assumes a divider value is not changed without the restart that any divider write brings. The stimulus changes settings only through complete single-cycle writes and keeps every divider small (1 to 5), so that whole periods fit in short measurement windows. Each new configuration ends with a divider write, which puts the phase at a known point before the bench counts high and low cycles.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int NCH     = 4;
  localparam int DIV_W   = 16;
  localparam int STEP_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int BYP_LSB = 8;   // bypass field position in the mode register
  localparam int SEL_LSB = 8;   // divider select position in the duty register

  // address regions, decoded from bus_addr[5:4]
  typedef enum logic [1:0] {
    RGN_MODE = 2'd0,
    RGN_DIV  = 2'd1,
    RGN_DUTY = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int N      = NCH,
  parameter int DW     = DIV_W,
  parameter int SW     = STEP_W,
  parameter int AW     = ADDR_W,
  parameter int XW     = DATA_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [XW-1:0]             wdata,
  output logic [XW-1:0]             rdata,
  output logic [N-1:0]              oe,
  output logic [N-1:0]              byp,
  output logic [N-1:0]              cen,
  output logic [N-1:0][DW-1:0]      div_val,
  output logic [N-1:0][SW-1:0]      duty_val,
  output logic [N-1:0][$clog2(N)-1:0] duty_sel,
  output logic [N-1:0]              div_wr,
  output logic [N-1:0]              duty_wr
);
  localparam int SEL_W = $clog2(N);
  localparam int IDX_LSB = 2;

  region_e            region;
  logic [SEL_W-1:0]   idx;
  logic               upper_zero;
  logic               mode_wr, cen_wr;

  assign idx        = addr[IDX_LSB +: SEL_W];
  assign upper_zero = (addr[AW-1:6] == '0) && (addr[1:0] == 2'b00);
  assign region     = upper_zero ? region_e'(addr[5:4]) : RGN_NONE;
  assign mode_wr    = we && region == RGN_MODE && idx == SEL_W'(0);
  assign cen_wr     = we && region == RGN_MODE && idx == SEL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe  <= '0;
      byp <= '0;
      cen <= '0;
    end else begin
      if (mode_wr) begin
        oe  <= wdata[N-1:0];
        byp <= wdata[BYP_LSB +: N];
      end
      if (cen_wr) cen <= wdata[N-1:0];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign div_wr[i]  = we && region == RGN_DIV  && idx == SEL_W'(i);
    assign duty_wr[i] = we && region == RGN_DUTY && idx == SEL_W'(i);

    always_ff @(posedge clk) begin
      if (rst) begin
        div_val[i]  <= '0;
        duty_val[i] <= '0;
        duty_sel[i] <= '0;
      end else begin
        if (div_wr[i]) div_val[i] <= wdata[DW-1:0];
        if (duty_wr[i]) begin
          duty_val[i] <= wdata[SW-1:0];
          duty_sel[i] <= wdata[SEL_LSB +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (region)
      RGN_MODE: begin
        if (idx == SEL_W'(0)) begin
          rdata[N-1:0]         = oe;
          rdata[BYP_LSB +: N]  = byp;
        end else if (idx == SEL_W'(1)) begin
          rdata[N-1:0] = cen;
        end
      end
      RGN_DIV:  rdata[DW-1:0] = div_val[idx];
      RGN_DUTY: begin
        rdata[SW-1:0]            = duty_val[idx];
        rdata[SEL_LSB +: SEL_W]  = duty_sel[idx];
      end
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_quad_div.sv
module pwm_quad_div #(
  parameter int DW = pwm_quad_pkg::DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          restart,
  input  logic [DW-1:0] period,
  output logic          tick
);
  logic [DW-1:0] cnt;
  logic          running;

  // last cycle of a divider interval
  function automatic logic at_wrap(input logic [DW-1:0] c, input logic [DW-1:0] d);
    return c == d - DW'(1);
  endfunction

  assign running = run_en && (period != '0);
  assign tick    = running && at_wrap(cnt, period);

  always_ff @(posedge clk) begin
    if (rst || restart || !running) cnt <= '0;
    else if (tick)                  cnt <= '0;
    else                            cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int SW = pwm_quad_pkg::STEP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_en,
  input  logic          bypass,
  input  logic          restart,
  input  logic          tick,
  input  logic [SW-1:0] duty,
  output logic [SW-1:0] step,
  output logic          pwm
);
  // normal polarity: high for the first duty steps of each period
  function automatic logic level(input logic en, input logic force_hi,
                                 input logic [SW-1:0] s, input logic [SW-1:0] d);
    return en && (force_hi || (s < d));
  endfunction

  always_ff @(posedge clk) begin
    if (rst || restart || !out_en) step <= '0;
    else if (tick)                 step <= step + SW'(1);
  end

  assign pwm = level(out_en, bypass, step, duty);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int N  = NCH,
  parameter int DW = DIV_W,
  parameter int SW = STEP_W,
  parameter int AW = ADDR_W,
  parameter int XW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [XW-1:0] bus_wdata,
  output logic [XW-1:0] bus_rdata,
  output logic [N-1:0]  pwm_out
);
  localparam int SEL_W = $clog2(N);

  logic [N-1:0]             oe, byp, cen;
  logic [N-1:0][DW-1:0]     div_val;
  logic [N-1:0][SW-1:0]     duty_val;
  logic [N-1:0][SEL_W-1:0]  duty_sel;
  logic [N-1:0]             div_wr, duty_wr;
  logic [N-1:0]             div_tick;     // divider tick events
  logic [N-1:0]             sel_tick;     // tick seen by each channel
  logic [N-1:0]             ch_restart;   // step counter restart events
  logic [N-1:0][SW-1:0]     step;

  pwm_quad_regs #(.N(N), .DW(DW), .SW(SW), .AW(AW), .XW(XW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .oe(oe), .byp(byp), .cen(cen), .div_val(div_val),
    .duty_val(duty_val), .duty_sel(duty_sel), .div_wr(div_wr), .duty_wr(duty_wr)
  );

  for (genvar i = 0; i < N; i++) begin : g_div
    pwm_quad_div #(.DW(DW)) u_div (
      .clk(clk), .rst(rst), .run_en(cen[i]), .restart(div_wr[i]),
      .period(div_val[i]), .tick(div_tick[i])
    );
  end

  for (genvar c = 0; c < N; c++) begin : g_chan
    assign sel_tick[c]   = div_tick[duty_sel[c]];
    assign ch_restart[c] = duty_wr[c] || div_wr[duty_sel[c]];

    pwm_quad_chan #(.SW(SW)) u_chan (
      .clk(clk), .rst(rst), .out_en(oe[c]), .bypass(byp[c]),
      .restart(ch_restart[c]), .tick(sel_tick[c]), .duty(duty_val[c]),
      .step(step[c]), .pwm(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int N  = pwm_quad_pkg::NCH,
  parameter int DW = pwm_quad_pkg::DIV_W,
  parameter int SW = pwm_quad_pkg::STEP_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N-1:0]         oe,
  input logic [N-1:0]         byp,
  input logic [N-1:0]         cen,
  input logic [N-1:0][DW-1:0] div_val,
  input logic [N-1:0][SW-1:0] duty_val,
  input logic [N-1:0]         div_tick,
  input logic [N-1:0]         sel_tick,
  input logic [N-1:0]         ch_restart,
  input logic [N-1:0][SW-1:0] step,
  input logic [N-1:0]         pwm_out
);
  for (genvar c = 0; c < N; c++) begin : g_chk
    assert_disabled_low_R7: assert property (@(posedge clk) disable iff (rst)
      !oe[c] |-> !pwm_out[c]);

    assert_bypass_high_R6: assert property (@(posedge clk) disable iff (rst)
      (oe[c] && byp[c]) |-> pwm_out[c]);

    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (rst)
      (!byp[c] && duty_val[c] == '0) |-> !pwm_out[c]);

    assert_no_tick_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
      (!cen[c] || div_val[c] == '0) |-> !div_tick[c]);

    assert_step_moves_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(step[c]) |-> $past(sel_tick[c] || ch_restart[c] || !oe[c]));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
      ch_restart[c] |=> step[c] == '0);

    assert_single_tick_R10: assert property (@(posedge clk) disable iff (rst)
      (div_tick[c] && div_val[c] > DW'(1)) |=> !div_tick[c]);
  end
endmodule

bind pwm_quad pwm_quad_chk #(.N(N), .DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .oe(oe), .byp(byp), .cen(cen), .div_val(div_val),
  .duty_val(duty_val), .div_tick(div_tick), .sel_tick(sel_tick),
  .ch_restart(ch_restart), .step(step), .pwm_out(pwm_out)
);

// File: tb/pwm_quad_test.sv
module pwm_quad_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int LIMIT      = 5000;
  localparam int NV         = 6;

  // divider values preset in dividers 0..3
  localparam int DV [4] = '{1, 2, 3, 5};
  // vector table: channel, divider select, duty
  localparam int VCH  [NV] = '{0, 1, 2, 3, 0, 2};
  localparam int VSEL [NV] = '{0, 1, 2, 3, 3, 1};
  localparam int VDUT [NV] = '{64, 100, 10, 200, 1, 255};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails  = 0;

  pwm_quad uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_high(int d, int duty);
    return d * duty;
  endfunction
  function automatic int exp_low(int d, int duty);
    return d * (256 - duty);
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  // called at the negedge right after a restart: counts high then low samples
  task automatic measure(input int ch, output int hi, output int lo);
    hi = 0; lo = 0;
    while (pwm_out[ch] && hi < LIMIT) begin hi++; @(negedge clk); end
    while (!pwm_out[ch] && lo < LIMIT) begin lo++; @(negedge clk); end
  endtask

  // number of high samples on a channel over n cycles
  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) h++;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v, hi, lo;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    chk("R1 outputs", int'(pwm_out), 0);
    rd(8'h00, v); chk("R1 mode", v, 0);
    rd(8'h04, v); chk("R1 count enable", v, 0);
    rd(8'h14, v); chk("R1 divider1", v, 0);
    rd(8'h2C, v); chk("R1 duty3", v, 0);

    // R2: readback masking
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 mode", v, 32'h0F0F);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 count enable", v, 32'h000F);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R2 divider2", v, 32'hFFFF);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); chk("R2 duty1", v, 32'h03FF);
    rd(8'hC0, v); chk("R2 unmapped", v, 0);
    wr(8'h00, 32'h0);

    // preset dividers
    for (int i = 0; i < 4; i++) wr(8'h10 + 8'(4*i), 32'(DV[i]));

    // R3/R4: vector table walk
    for (int n = 0; n < NV; n++) begin
      int ch, sel, dut;
      ch = VCH[n]; sel = VSEL[n]; dut = VDUT[n];
      wr(8'h20 + 8'(4*ch), 32'((sel << 8) | dut));
      wr(8'h00, 32'(1 << ch));
      wr(8'h04, 32'hF);
      wr(8'h10 + 8'(4*sel), 32'(DV[sel]));
      measure(ch, hi, lo);
      chk($sformatf("R3 R4 high time v%0d", n), hi, exp_high(DV[sel], dut));
      chk($sformatf("R3 R4 period v%0d", n), hi + lo, 256 * DV[sel]);
    end

    // R9: reconfigure divider in the middle of a period
    wr(8'h20, 32'((0 << 8) | 100));
    wr(8'h00, 32'h1);
    wr(8'h10, 32'd2);
    repeat (50) @(negedge clk);
    wr(8'h10, 32'd3);
    measure(0, hi, lo);
    chk("R9 high after mid-period change", hi, exp_high(3, 100));
    chk("R9 low after mid-period change", lo, exp_low(3, 100));

    // R5: zero duty stays low
    wr(8'h28, 32'((2 << 8) | 0));
    wr(8'h00, 32'h4);
    wr(8'h18, 32'd3);
    count_high(2, 800, v);
    chk("R5 zero duty high samples", v, 0);

    // R6: bypass forces high
    wr(8'h2C, 32'((3 << 8) | 0));
    wr(8'h00, 32'h0808);
    count_high(3, 600, v);
    chk("R6 bypass high samples", v, 600);

    // R7: output enable clear overrides bypass
    wr(8'h00, 32'h0F00);
    count_high(0, 300, hi);
    count_high(3, 10, lo);
    chk("R7 disabled outputs", hi + lo + int'(pwm_out), 0);

    // R8: count enable cleared freezes the step counter
    wr(8'h14, 32'd2);
    wr(8'h24, 32'((1 << 8) | 128));
    wr(8'h00, 32'h2);
    wr(8'h04, 32'hF);
    wr(8'h14, 32'd2);
    wr(8'h04, 32'h0);
    count_high(1, 400, v);
    chk("R8 frozen with count enable clear", v, 400);

    // R8: divider value 0 emits no ticks
    wr(8'h04, 32'hF);
    wr(8'h14, 32'd0);
    count_high(1, 400, v);
    chk("R8 frozen with zero divider", v, 400);

    // R10: divider value 1 ticks every cycle
    wr(8'h14, 32'd1);
    measure(1, hi, lo);
    chk("R10 one-cycle ticks high", hi, 128);
    chk("R10 one-cycle ticks period", hi + lo, 256);

    // R1: reset mid-run clears outputs and registers
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 outputs after reset", int'(pwm_out), 0);
    rd(8'h24, v); chk("R1 duty1 after reset", v, 0);

    summary();
    $finish;
  end
endmodule